// File: doc/BRIEF.md
# Coprocessor Escape Dispatch Unit

This unit sits between the decode stage of a simple in-order CPU and an external numeric coprocessor. It looks at each opcode byte the decode stage presents. The decode stage treats `in_ready` as permission to retire the byte.

An escape opcode carries a fixed five-bit prefix. The unit latches such an opcode, together with its operand address, into a single output slot. It offers that slot to the coprocessor over a valid/ready handshake. After the hand-off the CPU keeps running and does not wait for the arithmetic to finish. A WAIT opcode holds the decode stage until the coprocessor's BUSY pin, seen through a two-flop synchroniser, reads low.

A configuration input tells the unit whether a coprocessor is fitted. When none is fitted, escape opcodes are not forwarded. Each one instead produces a one-cycle trap pulse, which hands the instruction to software emulation. WAIT then completes at once.

Top module: `coproc_escape_dispatch`

## Requirements
- R1: An opcode is an escape opcode exactly when bits [7:3] equal 5'b11011 (0xD8 through 0xDF); any other byte (for example 0xD7 or 0xE0) is never placed on the coprocessor port.
- R2: With `coproc_present` high, an escape opcode accepted on a rising edge appears on `cp_valid`, `cp_opcode` and `cp_addr` from that edge onward, carrying the accepted opcode and address.
- R3: While `cp_valid` is high and `cp_ready` is low, `cp_opcode` and `cp_addr` hold their values, and a following escape opcode is refused (`in_ready` low) until the slot is taken.
- R4: Escape opcodes reach the coprocessor in the order in which they were accepted; the slot refills on the same edge on which `cp_ready` drains it.
- R5: An opcode that is neither an escape nor WAIT is accepted at once (`in_ready` high), even while the slot is full or BUSY is high.
- R6: WAIT is opcode 0x9B. With `coproc_present` high, `in_ready` stays low while the synchronised BUSY is high. BUSY passes through two flops, so `in_ready` rises after the second rising edge that follows BUSY going low.
- R7: With `coproc_present` low, an escape opcode is accepted at once and raises `emu_trap` for exactly the cycle after the accepting edge; `cp_valid` stays low.
- R8: With `coproc_present` low, WAIT is accepted at once whatever the state of BUSY, and it raises no trap.
- R9: After reset, `cp_valid` and `emu_trap` are low and an idle unit shows `in_ready` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, synchronous |
| coproc_present | input | 1 | High when a coprocessor is fitted |
| in_valid | input | 1 | Decode stage presents an opcode |
| in_opcode | input | 8 | Opcode byte from decode |
| in_addr | input | ADDR_W | Operand address from decode |
| in_ready | output | 1 | Opcode may retire on this edge |
| cp_valid | output | 1 | Coprocessor slot holds an instruction |
| cp_opcode | output | 8 | Escape opcode sent to the coprocessor |
| cp_addr | output | ADDR_W | Operand address sent to the coprocessor |
| cp_ready | input | 1 | Coprocessor takes the slot on this edge |
| cp_busy | input | 1 | Asynchronous BUSY pin from the coprocessor |
| emu_trap | output | 1 | One-cycle pulse requesting software emulation |

## Verification
`in_ready` depends on the current opcode and the current slot state with no register in between. The bench therefore samples it one time unit after driving inputs on the falling edge. The slot outputs and `emu_trap` are registered once, so they are checked at the falling edge that follows the accepting rising edge. The BUSY path adds two flops, so the WAIT release is checked as still low one falling edge after the pin drops and as high at the second. Before any WAIT stall is tested, BUSY is held for three cycles so that the synchroniser has settled.

// File: rtl/coproc_escape_dispatch.sv
module coproc_escape_dispatch #(
  parameter int          ADDR_W     = 32,
  parameter logic [4:0]  ESC_PREFIX = 5'b11011,
  parameter logic [7:0]  WAIT_OP    = 8'h9B
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              coproc_present,
  input  logic              in_valid,
  input  logic [7:0]        in_opcode,
  input  logic [ADDR_W-1:0] in_addr,
  output logic              in_ready,
  output logic              cp_valid,
  output logic [7:0]        cp_opcode,
  output logic [ADDR_W-1:0] cp_addr,
  input  logic              cp_ready,
  input  logic              cp_busy,
  output logic              emu_trap
);

  logic busy_s1, busy_s2;
  logic is_esc, is_wait, slot_free, accept;

  assign is_esc    = (in_opcode[7:3] == ESC_PREFIX);
  assign is_wait   = (in_opcode == WAIT_OP);
  assign slot_free = !cp_valid || cp_ready;

  always_comb begin
    if (is_esc && coproc_present)
      in_ready = slot_free;
    else if (is_wait && coproc_present)
      in_ready = !busy_s2;
    else
      in_ready = 1'b1;
  end

  assign accept = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_s1 <= 1'b0;
      busy_s2 <= 1'b0;
    end else begin
      busy_s1 <= cp_busy;
      busy_s2 <= busy_s1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cp_valid  <= 1'b0;
      cp_opcode <= '0;
      cp_addr   <= '0;
    end else if (accept && is_esc && coproc_present) begin
      cp_valid  <= 1'b1;
      cp_opcode <= in_opcode;
      cp_addr   <= in_addr;
    end else if (cp_ready) begin
      cp_valid  <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) emu_trap <= 1'b0;
    else        emu_trap <= accept && is_esc && !coproc_present;
  end

  a_r1_prefix_only: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cp_valid) |-> cp_opcode[7:3] == ESC_PREFIX);

  a_r2_forward: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && coproc_present && in_opcode[7:3] == ESC_PREFIX)
      |=> cp_valid && cp_opcode == $past(in_opcode) && cp_addr == $past(in_addr));

  a_r3_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (cp_valid && !cp_ready) |=> cp_valid && $stable(cp_opcode) && $stable(cp_addr));

  a_r3_refuse: assert property (@(posedge clk) disable iff (!rst_n)
    (cp_valid && !cp_ready && coproc_present && in_opcode[7:3] == ESC_PREFIX) |-> !in_ready);

  a_r5_no_stall: assert property (@(posedge clk) disable iff (!rst_n)
    (in_opcode[7:3] != ESC_PREFIX && in_opcode != WAIT_OP) |-> in_ready);

  a_r7_trap_cause: assert property (@(posedge clk) disable iff (!rst_n)
    emu_trap |-> $past(in_valid && in_ready && !coproc_present && in_opcode[7:3] == ESC_PREFIX));

  a_r8_absent_wait: assert property (@(posedge clk) disable iff (!rst_n)
    (!coproc_present && in_opcode == WAIT_OP) |-> in_ready);

endmodule

// File: tb/tb_coproc_escape_dispatch.sv
module tb_coproc_escape_dispatch;
  localparam int AW = 32;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          coproc_present = 1'b1;
  logic          in_valid = 1'b0;
  logic [7:0]    in_opcode = 8'h00;
  logic [AW-1:0] in_addr = '0;
  logic          in_ready;
  logic          cp_valid;
  logic [7:0]    cp_opcode;
  logic [AW-1:0] cp_addr;
  logic          cp_ready = 1'b1;
  logic          cp_busy = 1'b0;
  logic          emu_trap;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  coproc_escape_dispatch #(.ADDR_W(AW)) dut (
    .clk(clk), .rst_n(rst_n), .coproc_present(coproc_present),
    .in_valid(in_valid), .in_opcode(in_opcode), .in_addr(in_addr),
    .in_ready(in_ready), .cp_valid(cp_valid), .cp_opcode(cp_opcode),
    .cp_addr(cp_addr), .cp_ready(cp_ready), .cp_busy(cp_busy),
    .emu_trap(emu_trap)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
    #1;
  endtask

  task automatic present_op(input logic [7:0] op, input logic [AW-1:0] a);
    in_valid  = 1'b1;
    in_opcode = op;
    in_addr   = a;
    #1;
  endtask

  task automatic idle();
    in_valid  = 1'b0;
    in_opcode = 8'h00;
  endtask

  task automatic t_reset();
    check("R9 cp_valid", cp_valid, 0);
    check("R9 emu_trap", emu_trap, 0);
    check("R9 in_ready", in_ready, 1);
  endtask

  task automatic t_forward();
    logic [7:0] ops [4] = '{8'hD8, 8'hDF, 8'hD7, 8'hE0};
    cp_ready = 1'b1;
    foreach (ops[i]) begin
      present_op(ops[i], AW'(32'h1000 + i));
      check("R1 in_ready", in_ready, 1);
      step();
      idle();
      if (ops[i][7:3] == 5'b11011) begin
        check("R2 cp_valid", cp_valid, 1);
        check("R2 cp_opcode", cp_opcode, ops[i]);
        check("R2 cp_addr", cp_addr, 32'h1000 + i);
      end else begin
        check("R1 not forwarded", cp_valid, 0);
      end
      step();
      check("R2 slot drained", cp_valid, 0);
    end
  endtask

  task automatic t_backpressure();
    cp_ready = 1'b0;
    present_op(8'hD9, 32'hA0A0);
    step();
    check("R2 first loaded", cp_opcode, 8'hD9);
    present_op(8'hDA, 32'hB0B0);
    check("R3 refuse", in_ready, 0);
    for (int k = 0; k < 3; k++) begin
      step();
      check("R3 hold opcode", cp_opcode, 8'hD9);
      check("R3 hold addr", cp_addr, 32'hA0A0);
      check("R3 still refused", in_ready, 0);
    end
    cp_ready = 1'b1;
    #1;
    check("R4 accept on drain", in_ready, 1);
    step();
    idle();
    check("R4 second valid", cp_valid, 1);
    check("R4 second opcode", cp_opcode, 8'hDA);
    check("R4 second addr", cp_addr, 32'hB0B0);
    step();
    check("R4 drained", cp_valid, 0);
  endtask

  task automatic t_concurrent();
    cp_ready = 1'b0;
    cp_busy  = 1'b1;
    present_op(8'hDC, 32'h55);
    step();
    present_op(8'h90, 32'h0);
    check("R5 runs past full slot", in_ready, 1);
    step();
    step();
    check("R5 runs while busy", in_ready, 1);
    check("R5 slot kept", cp_opcode, 8'hDC);
    idle();
    cp_ready = 1'b1;
    cp_busy  = 1'b0;
    step();
    step();
    step();
  endtask

  task automatic t_wait();
    coproc_present = 1'b1;
    cp_busy = 1'b1;
    step(); step(); step();
    present_op(8'h9B, 32'h0);
    check("R6 stall", in_ready, 0);
    for (int k = 0; k < 4; k++) begin
      step();
      check("R6 stall held", in_ready, 0);
    end
    cp_busy = 1'b0;
    #1;
    check("R6 no early release", in_ready, 0);
    step();
    check("R6 one flop", in_ready, 0);
    step();
    check("R6 released", in_ready, 1);
    step();
    check("R6 busy low no stall", in_ready, 1);
    idle();
  endtask

  task automatic t_absent();
    coproc_present = 1'b0;
    cp_ready = 1'b1;
    present_op(8'hDE, 32'h77);
    check("R7 accepted", in_ready, 1);
    step();
    idle();
    check("R7 trap", emu_trap, 1);
    check("R7 not forwarded", cp_valid, 0);
    step();
    check("R7 trap one cycle", emu_trap, 0);
    cp_busy = 1'b1;
    step(); step(); step();
    present_op(8'h9B, 32'h0);
    check("R8 wait passes", in_ready, 1);
    step();
    idle();
    check("R8 no trap", emu_trap, 0);
    cp_busy = 1'b0;
    coproc_present = 1'b1;
    step(); step(); step();
  endtask

  initial begin
    repeat (3) step();
    rst_n = 1'b1;
    step();
    t_reset();
    t_forward();
    t_backpressure();
    t_concurrent();
    t_wait();
    t_absent();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    #200000;
    if (!done) begin
      done = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule